// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block takes one active-low external interrupt pin and turns it into the request flag that an interrupt controller reads. The pin first passes through a chain of synchroniser flops. It is then sampled only on a machine-cycle strobe, so its timing is measured in machine cycles and not in clock cycles.

A mode input selects how the pin is read. With the mode bit at 0 the block is level sensitive. The request follows the pin, but only after the pin has read low on a run of consecutive samples. With the mode bit at 1 the block is edge sensitive. A high sample followed by a low sample sets a sticky flag. That flag ignores further edges until the controller acknowledges the vector or software clears it. Software can also write the flag directly.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset the request output is 0, and the registered pin sample reads high, so a pin already high at reset produces no edge.
- R2: The pin reaches the sampler through a two-flop synchroniser, and the sample changes only on a cycle where the strobe is 1; a low pin with no strobe never raises a request.
- R3: In level mode (mode bit 0) the request rises at the fourth consecutive strobe that samples the pin low, and not at the third.
- R4: In level mode a strobe that samples the pin high drops the request and restarts the low-sample run from zero.
- R5: In level mode an acknowledge does not clear the request while the pin is still low; it stays 1 through later strobes.
- R6: In edge mode (mode bit 1) a strobe sample of low that follows a strobe sample of high sets the flag, and the request reads 1 from the next clock on.
- R7: In edge mode, further falling edges while the flag is 1 are ignored: after the acknowledge clears the flag, no second request is pending.
- R8: An acknowledge clears the flag one clock later, and a pin that stays low afterwards does not set it again.
- R9: A software write with data 1 sets the flag and with data 0 clears it, in either mode; in level mode the flag still drives the request.
- R10: A software write takes precedence over an acknowledge or a falling edge in the same clock.
- R11: A change of the mode bit clears any partial low-sample count, so the level request needs four fresh low samples after the change.
- R12: In level mode an edge does not latch anything: once the pin returns high, the request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irqPinN | input | 1 | Asynchronous external interrupt pin, active low |
| edgeMode | input | 1 | 0 selects level mode, 1 selects falling-edge mode |
| cycleStb | input | 1 | One-clock machine-cycle strobe that qualifies each pin sample |
| irqAck | input | 1 | Controller pulse that marks this interrupt as vectored |
| swWrEn | input | 1 | Software write enable for the flag |
| swWrData | input | 1 | Value written to the flag |
| irqReq | output | 1 | Request flag seen by the interrupt controller |

## Verification
The assertions assume that the strobe and the acknowledge are single-clock pulses driven synchronously to the clock. They also assume that the pin holds its level long enough to clear the synchroniser before the strobe that should see it. The bench keeps to this by changing the pin only at falling clock edges and at least three clocks before the strobe it targets. It raises the strobe, the acknowledge and the software write for exactly one clock each. The one case where a write and an edge land in the same clock is built on purpose, to check the precedence.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  // Strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic sampleEn;  // take a new pin sample this clock
    logic clrCount;  // drop any partial low-level run
  } dpCtrl_t;
endpackage

// File: rtl/ext_irq_dp.sv
module ext_irq_dp
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_SAMPLES = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    irqPinN,
  input  dpCtrl_t ctrl,
  output logic    fallSeen,
  output logic    levelQual
);
  localparam int CNT_W = $clog2(LOW_SAMPLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOW_SAMPLES);

  logic [SYNC_STAGES-1:0] syncQ;
  logic syncPin;
  logic smpQ;
  logic [CNT_W-1:0] lowCnt;

  // Synchroniser chain, idle value high.
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) syncQ[0] <= 1'b1;
          else        syncQ[0] <= irqPinN;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) syncQ[i] <= 1'b1;
          else        syncQ[i] <= syncQ[i-1];
      end
    end
  endgenerate

  assign syncPin = syncQ[SYNC_STAGES-1];

  // Registered machine-cycle sample.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             smpQ <= 1'b1;
    else if (ctrl.sampleEn) smpQ <= syncPin;

  // Saturating run length of low samples.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             lowCnt <= '0;
    else if (ctrl.clrCount) lowCnt <= '0;
    else if (ctrl.sampleEn) begin
      if (syncPin)               lowCnt <= '0;
      else if (lowCnt != CNT_MAX) lowCnt <= lowCnt + 1'b1;
    end

  assign levelQual = (lowCnt == CNT_MAX);
  assign fallSeen  = ctrl.sampleEn && smpQ && !syncPin;

  // R2
  smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.sampleEn |=> $stable(smpQ));
  // R3
  qual_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(levelQual) |-> ($past(ctrl.sampleEn) && !$past(syncPin)));
  // R11
  clr_drops_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.clrCount |=> !levelQual);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    edgeMode,
  input  logic    cycleStb,
  input  logic    irqAck,
  input  logic    swWrEn,
  input  logic    swWrData,
  input  logic    fallSeen,
  input  logic    levelQual,
  output dpCtrl_t dpCtrl,
  output logic    irqReq
);
  logic modeQ;
  logic flagQ;
  logic flagNext;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) modeQ <= 1'b0;
    else        modeQ <= edgeMode;

  always_comb begin
    dpCtrl.sampleEn = cycleStb;
    dpCtrl.clrCount = (edgeMode != modeQ);
  end

  // Precedence: software write, then acknowledge, then edge.
  always_comb begin
    flagNext = flagQ;
    if (swWrEn)                     flagNext = swWrData;
    else if (irqAck)                flagNext = 1'b0;
    else if (edgeMode && fallSeen)  flagNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flagQ <= 1'b0;
    else        flagQ <= flagNext;

  assign irqReq = flagQ || (!edgeMode && levelQual);

  // R7
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagQ && !irqAck && !swWrEn) |=> flagQ);
  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irqAck && !swWrEn) |=> !flagQ);
  // R10
  sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swWrEn |=> (flagQ == $past(swWrData)));
  // R12
  level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edgeMode && !flagQ && !swWrEn) |=> !flagQ);
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_SAMPLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irqPinN,
  input  logic edgeMode,
  input  logic cycleStb,
  input  logic irqAck,
  input  logic swWrEn,
  input  logic swWrData,
  output logic irqReq
);
  dpCtrl_t dpCtrl;
  logic fallSeen;
  logic levelQual;

  ext_irq_dp #(.SYNC_STAGES(SYNC_STAGES), .LOW_SAMPLES(LOW_SAMPLES)) dp_i (
    .clk(clk), .rst_n(rst_n), .irqPinN(irqPinN), .ctrl(dpCtrl),
    .fallSeen(fallSeen), .levelQual(levelQual)
  );

  ext_irq_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .edgeMode(edgeMode), .cycleStb(cycleStb),
    .irqAck(irqAck), .swWrEn(swWrEn), .swWrData(swWrData),
    .fallSeen(fallSeen), .levelQual(levelQual),
    .dpCtrl(dpCtrl), .irqReq(irqReq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !irqReq);
endmodule

// File: tb/ext_irq_detect_tb_top.sv
module ext_irq_detect_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irqPinN = 1'b1;
  logic edgeMode = 1'b0;
  logic cycleStb = 1'b0;
  logic irqAck = 1'b0;
  logic swWrEn = 1'b0;
  logic swWrData = 1'b0;
  logic irqReq;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ext_irq_detect dut_i (
    .clk(clk), .rst_n(rst_n), .irqPinN(irqPinN), .edgeMode(edgeMode),
    .cycleStb(cycleStb), .irqAck(irqAck), .swWrEn(swWrEn),
    .swWrData(swWrData), .irqReq(irqReq)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (irqReq !== exp) begin
      fails++;
      $display("FAIL %s irqReq actual=%b expected=%b t=%0t", req, irqReq, exp, $time);
    end
  endtask

  // Three settling clocks, then a one-clock strobe; returns at a falling edge.
  task automatic strobe();
    repeat (3) @(negedge clk);
    cycleStb = 1'b1;
    @(negedge clk);
    cycleStb = 1'b0;
  endtask

  task automatic ackPulse();
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic swWrite(input logic v);
    swWrEn = 1'b1; swWrData = v;
    @(negedge clk);
    swWrEn = 1'b0;
  endtask

  task automatic t_reset();
    check(1'b0, "R1 reset");
  endtask

  task automatic t_level();
    irqPinN = 1'b0;
    repeat (20) @(negedge clk);
    check(1'b0, "R2 no strobe");
    strobe(); strobe(); strobe();
    check(1'b0, "R3 three lows");
    strobe();
    check(1'b1, "R3 four lows");
    ackPulse();
    check(1'b1, "R5 ack while low");
    strobe();
    check(1'b1, "R5 still low");
    irqPinN = 1'b1; strobe();
    check(1'b0, "R4 high sample");
  endtask

  task automatic t_level_no_latch();
    irqPinN = 1'b0; strobe();
    check(1'b0, "R12 one low");
    irqPinN = 1'b1; strobe();
    check(1'b0, "R12 back high");
  endtask

  task automatic t_mode_clear();
    irqPinN = 1'b0;
    strobe(); strobe(); strobe();
    edgeMode = 1'b1; @(negedge clk);
    edgeMode = 1'b0; @(negedge clk);
    strobe();
    check(1'b0, "R11 count cleared");
    strobe(); strobe();
    check(1'b0, "R11 three after clear");
    strobe();
    check(1'b1, "R11 four after clear");
    irqPinN = 1'b1; strobe();
    check(1'b0, "R4 release");
  endtask

  task automatic t_edge();
    edgeMode = 1'b1; irqPinN = 1'b1; strobe();
    check(1'b0, "R6 idle high");
    irqPinN = 1'b0; strobe();
    check(1'b1, "R6 falling edge");
    irqPinN = 1'b1; strobe();
    irqPinN = 1'b0; strobe();
    check(1'b1, "R7 flag held");
    ackPulse();
    check(1'b0, "R7 no queued edge");
    strobe();
    check(1'b0, "R8 low after ack");
    irqPinN = 1'b1; strobe();
    irqPinN = 1'b0; strobe();
    check(1'b1, "R6 new edge");
    ackPulse();
    check(1'b0, "R8 ack clears");
  endtask

  task automatic t_sw();
    irqPinN = 1'b1;
    swWrite(1'b1);
    check(1'b1, "R9 write 1 edge mode");
    swWrite(1'b0);
    check(1'b0, "R9 write 0 edge mode");
    edgeMode = 1'b0; @(negedge clk);
    swWrite(1'b1);
    check(1'b1, "R9 write 1 level mode");
    swWrite(1'b0);
    check(1'b0, "R9 write 0 level mode");
    swWrite(1'b1);
    irqAck = 1'b1; swWrEn = 1'b1; swWrData = 1'b1;
    @(negedge clk);
    irqAck = 1'b0; swWrEn = 1'b0;
    check(1'b1, "R10 write beats ack");
    swWrite(1'b0);
  endtask

  task automatic t_sw_vs_edge();
    edgeMode = 1'b1; irqPinN = 1'b1; strobe();
    irqPinN = 1'b0;
    repeat (3) @(negedge clk);
    cycleStb = 1'b1; swWrEn = 1'b1; swWrData = 1'b0;
    @(negedge clk);
    cycleStb = 1'b0; swWrEn = 1'b0;
    check(1'b0, "R10 write beats edge");
    strobe();
    check(1'b0, "R10 no later edge");
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_level_no_latch();
    t_mode_clear();
    t_edge();
    t_sw();
    t_sw_vs_edge();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule